// File: doc/BRIEF.md
# Single-Cycle Mesh Flit Router

A five-port router for one node of a two-dimensional mesh. Four ports face the neighbouring routers (north, south, east, west) and a fifth faces the processor attached to the node. Every packet is a single flit, so an output is claimed for exactly one cycle and no route is ever held open. Each input buffers up to two flits in a small FIFO, which absorbs short bursts of congestion. Each output runs its own round-robin arbiter, and all five outputs are arbitrated in every cycle, so up to five flits can move through the router at once.

Routing is dimension-ordered. The router compares the destination coordinates carried in the flit with its own coordinate parameters and sends the flit east or west until the X offset is gone, then north or south, and finally out of the processor port. There is no pipeline register between an input FIFO head and an output, so a flit crosses one hop per clock. The flit width is a parameter, so the same block serves a wide data network and a narrow credit-return network.

All ports are valid/ready. An input flit is taken on a rising edge where `in_valid` and `in_ready` are both high; `in_ready` is low exactly when that input's FIFO holds two flits. An output flit is delivered on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the flit stays in its FIFO and is offered again. Because arbitration is repeated every cycle, the flit on a stalled output may be replaced by another one before it is taken.

Top module: `mesh_flit_router`

## Requirements
- R1: After reset every `in_ready` bit is 1 and every `out_valid` bit is 0.
- R2: The destination X sits in flit bits [X_W-1:0]. If it is greater than MY_X the flit leaves on port 3 (east). If it is smaller, it leaves on port 4 (west).
- R3: When the destination X equals MY_X, the destination Y, held in bits [X_W+Y_W-1:X_W], selects the exit: greater than MY_Y gives port 2 (south), smaller gives port 1 (north), and equal gives port 0 (processor).
- R4: Each input holds at most two flits, and its `in_ready` is 0 exactly when it holds two.
- R5: A flit taken at an edge is offered on its output in the very next cycle, with its data unchanged, provided it is the head of its FIFO and wins arbitration.
- R6: Each output grants the first requesting input found when scanning port indices upward from its pointer, wrapping from 4 to 0. The pointer moves to one past the granted index only on a cycle where `out_valid` and `out_ready` are both 1.
- R7: A granted flit leaves its FIFO on the same edge that its output's `out_ready` is 1. While `out_ready` is 0 it stays in the FIFO.
- R8: A flit that would leave on the port it came in on is never granted, and it stays at the head of its FIFO.
- R9: All five outputs are arbitrated independently in the same cycle, and each input is popped by at most one output per edge.
- R10: Flits from one input leave in the order in which they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | Per-input flit valid, index 0 processor, 1 N, 2 S, 3 E, 4 W |
| in_data | input | 5*FLIT_W | Input flits, port p at bits [p*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Per-input space available |
| out_valid | output | 5 | Per-output flit valid, same port indexing |
| out_data | output | 5*FLIT_W | Output flits, same slicing as in_data |
| out_ready | input | 5 | Per-output downstream acceptance |

## Verification
Every result here is due at a fixed point. `in_ready` reflects FIFO occupancy in the cycle after a push or pop. A flit accepted at an edge is offered at its output in the next cycle. A pop and a pointer move take effect at the edge where the grant meets `out_ready`. The bench drives its inputs on the falling edge, then compares `in_ready`, `out_valid` and the valid `out_data` with a queue-based model shortly afterwards. After that it steps the model with the same inputs, so both advance on the same rising edge, and every cycle is compared.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NPORT  = 5;
  localparam int PIDX_W = 3;
  localparam int P_LOC  = 0;
  localparam int P_NORTH = 1;
  localparam int P_SOUTH = 2;
  localparam int P_EAST  = 3;
  localparam int P_WEST  = 4;
endpackage

// File: rtl/mr_flit_fifo.sv
module mr_flit_fifo #(
  parameter int W     = 80,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  output logic         head_valid,
  output logic [W-1:0] head_data,
  input  logic         pop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign push_ready = (count != FULL);
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // R4: occupancy never exceeds DEPTH
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  // R7: a pop without a push lowers occupancy by one
  assert_pop_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (count == $past(count) - 1'b1));
  // R10: a lone push on an empty FIFO becomes the head
  assert_first_in_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && count == '0) |=> (head_data == $past(push_data)));
endmodule

// File: rtl/mr_dor_route.sv
module mr_dor_route
  import mesh_router_pkg::*;
#(
  parameter int FLIT_W = 80,
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int MY_X   = 2,
  parameter int MY_Y   = 2
) (
  input  logic [FLIT_W-1:0] flit,
  input  logic              vld,
  output logic [NPORT-1:0]  dir
);
  localparam logic [X_W-1:0] HOME_X = X_W'(MY_X);
  localparam logic [Y_W-1:0] HOME_Y = Y_W'(MY_Y);

  logic [X_W-1:0] dst_x;
  logic [Y_W-1:0] dst_y;

  assign dst_x = flit[X_W-1:0];
  assign dst_y = flit[X_W+Y_W-1:X_W];

  always_comb begin
    dir = '0;
    if (vld) begin
      if (dst_x > HOME_X)      dir[P_EAST]  = 1'b1;
      else if (dst_x < HOME_X) dir[P_WEST]  = 1'b1;
      else if (dst_y > HOME_Y) dir[P_SOUTH] = 1'b1;
      else if (dst_y < HOME_Y) dir[P_NORTH] = 1'b1;
      else                     dir[P_LOC]   = 1'b1;
    end
  end
endmodule

// File: rtl/mr_rr_arb.sv
module mr_rr_arb #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] gnt,
  output logic         any_gnt
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] win_idx;

  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    win_idx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win_idx  = IW'(idx);
      end
    end
    any_gnt = found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (advance && any_gnt)
      ptr <= (win_idx == IW'(N - 1)) ? '0 : win_idx + 1'b1;
  end

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  assert_ptr_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && any_gnt) |=> $stable(ptr));
  assert_ptr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < IW'(N));
endmodule

// File: rtl/mesh_flit_router.sv
module mesh_flit_router
  import mesh_router_pkg::*;
#(
  parameter int FLIT_W     = 80,
  parameter int X_W        = 3,
  parameter int Y_W        = 3,
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*FLIT_W-1:0] in_data,
  output logic [NPORT-1:0]        in_ready,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT*FLIT_W-1:0] out_data,
  input  logic [NPORT-1:0]        out_ready
);
  logic [FLIT_W-1:0] head     [NPORT];
  logic [NPORT-1:0]  head_vld;
  logic [NPORT-1:0]  dir      [NPORT];
  logic [NPORT-1:0]  req_to   [NPORT];
  logic [NPORT-1:0]  gnt      [NPORT];
  logic [NPORT-1:0]  pop;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    mr_flit_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_valid[i]),
      .push_data  (in_data[i*FLIT_W +: FLIT_W]),
      .push_ready (in_ready[i]),
      .head_valid (head_vld[i]),
      .head_data  (head[i]),
      .pop        (pop[i])
    );
    mr_dor_route #(.FLIT_W(FLIT_W), .X_W(X_W), .Y_W(Y_W),
                   .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .flit (head[i]),
      .vld  (head_vld[i]),
      .dir  (dir[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic any;
    for (genvar i = 0; i < NPORT; i++) begin : g_req
      if (i == o) begin : g_uturn
        assign req_to[o][i] = 1'b0;
      end else begin : g_legal
        assign req_to[o][i] = dir[i][o];
      end
    end
    mr_rr_arb #(.N(NPORT), .IW(PIDX_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_to[o]),
      .advance (out_ready[o]),
      .gnt     (gnt[o]),
      .any_gnt (any)
    );
    assign out_valid[o] = any;

    always_comb begin
      logic [FLIT_W-1:0] sel;
      sel = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt[o][i]) sel = sel | head[i];
      out_data[o*FLIT_W +: FLIT_W] = sel;
    end

    // R8: the input arriving on this port is never granted back to it
    assert_no_uturn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[o][o] == 1'b0);
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (gnt[o][i] && out_ready[o]) pop[i] = 1'b1;
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    logic [NPORT-1:0] col;
    for (genvar o = 0; o < NPORT; o++) begin : g_col
      assign col[o] = gnt[o][i];
    end
    // R9: one input is granted by at most one output per cycle
    assert_single_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
    // R7: a pop only happens on a non-empty input
    assert_pop_has_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop[i] |-> head_vld[i]);
  end
endmodule

// File: tb/tb_mesh_flit_router.sv
`timescale 1ns/1ps
module tb_mesh_flit_router;
  localparam int NP = 5;
  localparam int FW = 80;
  localparam int XW = 3;
  localparam int YW = 3;
  localparam int HX = 2;
  localparam int HY = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP*FW-1:0]  in_data = '0;
  logic [NP-1:0]     in_ready;
  logic [NP-1:0]     out_valid;
  logic [NP*FW-1:0]  out_data;
  logic [NP-1:0]     out_ready = '0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  int serial  = 1;

  logic [FW-1:0] q [NP][$];
  int            rr [NP];

  always #2.5 clk = ~clk;

  mesh_flit_router #(.FLIT_W(FW), .X_W(XW), .Y_W(YW), .MY_X(HX), .MY_Y(HY),
                     .FIFO_DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready));

  // R2 R3: exit port from destination, 0 proc, 1 N, 2 S, 3 E, 4 W
  function automatic int exit_of(logic [FW-1:0] f);
    int dx, dy;
    dx = int'(f[XW-1:0]);
    dy = int'(f[XW+YW-1:XW]);
    if (dx > HX) return 3;
    if (dx < HX) return 4;
    if (dy > HY) return 2;
    if (dy < HY) return 1;
    return 0;
  endfunction

  function automatic logic [FW-1:0] mk(int dx, int dy);
    logic [FW-1:0] f;
    f = '0;
    f[XW-1:0] = XW'(dx);
    f[XW+YW-1:XW] = YW'(dy);
    f[FW-1:32] = 48'(serial);
    serial++;
    return f;
  endfunction

  // random flit that is not a U-turn for input i
  function automatic logic [FW-1:0] legal_flit(int i);
    logic [FW-1:0] f;
    f = mk($urandom % 8, $urandom % 8);
    while (exit_of(f) == i) f = mk($urandom % 8, $urandom % 8);
    return f;
  endfunction

  task automatic check(bit ok, string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare DUT with model, then advance the model by one edge
  task automatic compare_and_step();
    int win [NP];
    bit popq [NP];
    for (int i = 0; i < NP; i++) begin
      check(in_ready[i] == (q[i].size() < 2), "R4 in_ready",
            FW'(in_ready[i]), FW'(q[i].size() < 2));
      popq[i] = 0;
    end
    for (int o = 0; o < NP; o++) begin
      win[o] = -1;
      for (int k = 0; k < NP; k++) begin
        int idx;
        idx = (rr[o] + k) % NP;
        if (win[o] < 0 && idx != o && q[idx].size() > 0 && exit_of(q[idx][0]) == o)
          win[o] = idx;
      end
      check(out_valid[o] == (win[o] >= 0), "R6 R8 R9 out_valid",
            FW'(out_valid[o]), FW'(win[o] >= 0));
      if (win[o] >= 0)
        check(out_data[o*FW +: FW] == q[win[o]][0], "R2 R3 R5 R6 R10 out_data",
              out_data[o*FW +: FW], q[win[o]][0]);
    end
    for (int o = 0; o < NP; o++)
      if (win[o] >= 0 && out_ready[o]) begin
        popq[win[o]] = 1;           // R7
        rr[o] = (win[o] + 1) % NP;
      end
    for (int i = 0; i < NP; i++) begin
      bit room;
      room = q[i].size() < 2;
      if (popq[i]) void'(q[i].pop_front());
      if (in_valid[i] && room) q[i].push_back(in_data[i*FW +: FW]);
    end
  endtask

  task automatic cycle();
    #1;
    compare_and_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < NP; o++) rr[o] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == '1, "R1 in_ready", FW'(in_ready), FW'(5'h1f));
    check(out_valid == '0, "R1 out_valid", FW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: single flit from processor heading east, due the next cycle
    out_ready = '1;
    in_valid = 5'b00001;
    in_data[0 +: FW] = mk(5, 2);
    cycle();
    in_valid = '0;
    #1;
    check(out_valid[3] == 1'b1, "R5 one-hop latency", FW'(out_valid[3]), FW'(1));
    compare_and_step();
    @(negedge clk);

    // R3: north input delivered locally, west input to north
    in_valid = 5'b10010;
    in_data[1*FW +: FW] = mk(HX, HY);
    in_data[4*FW +: FW] = mk(HX, 0);
    cycle();
    in_valid = '0;
    cycle();

    // R4 R7: stall all outputs and fill every FIFO
    out_ready = '0;
    for (int c = 0; c < 6; c++) begin
      for (int i = 0; i < NP; i++) begin
        in_valid[i] = 1'b1;
        in_data[i*FW +: FW] = legal_flit(i);
      end
      cycle();
    end
    in_valid = '0;
    out_ready = '1;
    repeat (6) cycle();

    // R6 R10: hotspot, every neighbour input targets the processor port
    for (int c = 0; c < 60; c++) begin
      in_valid = 5'b11110;
      for (int i = 1; i < NP; i++) in_data[i*FW +: FW] = mk(HX, HY);
      out_ready = 5'b11110 | 5'(c % 3 != 0);
      cycle();
    end
    in_valid = '0;
    out_ready = '1;
    repeat (6) cycle();

    // R2 R3 R6 R7 R9 R10: random traffic and random back-pressure
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < NP; i++) begin
        in_valid[i] = ($urandom % 4) != 0;
        in_data[i*FW +: FW] = legal_flit(i);
        out_ready[i] = ($urandom % 10) < 7;
      end
      cycle();
    end
    in_valid = '0;
    out_ready = '1;
    repeat (8) cycle();

    // R8: a north input heading north is a U-turn and is never sent
    in_valid = 5'b00010;
    in_data[1*FW +: FW] = mk(HX, 0);
    cycle();
    in_data[1*FW +: FW] = mk(HX, 1);
    cycle();
    in_valid = '0;
    for (int c = 0; c < 10; c++) begin
      #1;
      check(out_valid[1] == 1'b0, "R8 no U-turn grant", FW'(out_valid[1]), '0);
      check(in_ready[1] == 1'b0, "R8 U-turn flits held", FW'(in_ready[1]), '0);
      compare_and_step();
      @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule